// File: doc/BRIEF.md
# Aliased Register Window with Per-Page Write Protection

This block sits in front of a peripheral's register file and presents the same registers through several 4 KiB pages. Page 0 is the primary page and has full write access. Pages 1 to NUM_ALIAS are alias pages. Each alias page can be mapped into a separate software instance through an MMU. A write arriving through an alias page lands only if that page's access-control mask opens the target register. The register must also not belong to the privileged set.

The access-control masks are held in registers of their own. They sit after the storage registers in every page, one per alias page, and they can be written only through the primary page. Software programs them from page 0 before it starts the instances that use the alias pages. A read returns the same data whichever in-window page it arrives through. A write that is refused completes like any other, and the register keeps its value.

The bus is a single-cycle request port. A write takes effect at the clock edge that samples it. Read data appears on `rdata_o` after the clock edge that samples the read request, and `rdata_o` holds that value until the next read.

Top module: `mrw_window`

## Requirements
- R1: After reset, every storage register and every access-control mask reads 0, `rdata_o` is 0, and every alias page is fully write-protected.
- R2: A write through page 0 (address bits [14:12] = 0) updates the addressed storage register or access-control mask. The register index is address bits [11:2]. Storage registers are indices 0 to 7, and the mask for alias page n is index 7+n.
- R3: A read through any page 0 to 4 returns the value of the addressed register on `rdata_o` one clock edge after the request. The value is the same as a read through page 0.
- R4: A write through alias page n (n = 1 to 4) to a non-privileged storage register i takes effect only when bit i of the mask for page n is 1.
- R5: Storage registers 0, 1 and 2 are privileged. No alias page can write them, whatever the mask says.
- R6: No alias page can write an access-control mask.
- R7: Page numbers 5 and above are outside the window. Reads there return 0, and writes there change no register.
- R8: Within a page, indices 12 and above hold no register. Reads there return 0, and writes there change no register.
- R9: The masks of different alias pages are independent. Opening a register for one page leaves it closed for the others.
- R10: A mask stores only bits [7:0]. Bits [31:8] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled on the rising edge |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 15 | Byte offset from the block base: page in [14:12], register index in [11:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, held between reads |

## Verification
The bench drives the same register through the primary page and through alias pages, with the mask bit both closed and open. This separates the page-0 bypass from mask gating. It opens a register on one alias page and writes to it through another, which shows whether the masks are kept per page. It aims alias writes at privileged registers and at the masks while every mask bit is set, which checks the fixed privilege set apart from the programmable one. It also addresses pages and indices just past the populated range, and checks the truncated upper bits of a mask.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  localparam int unsigned MRW_NUM_REGS  = 8;
  localparam int unsigned MRW_NUM_ALIAS = 4;
  localparam int unsigned MRW_DATA_W    = 32;
  localparam int unsigned MRW_PAGE_OFS  = 12;  // 4 KiB pages
  localparam int unsigned MRW_IDX_W     = 10;  // word index within a page
  localparam logic [MRW_NUM_REGS-1:0] MRW_PRIV_MASK = 8'h07;
endpackage

// File: rtl/mrw_decode.sv
module mrw_decode #(
  parameter int unsigned NUM_ALIAS = 4,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned IDX_W     = 10,
  localparam int unsigned ADDR_W   = 12 + PAGE_W
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 in_window_o,
  output logic                 is_primary_o,
  output logic [NUM_ALIAS-1:0] alias_sel_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [PAGE_W-1:0] page;

  assign page         = addr_i[ADDR_W-1:12];
  assign idx_o        = addr_i[11:2];
  assign in_window_o  = (page <= PAGE_W'(NUM_ALIAS));
  assign is_primary_o = (page == '0);

  for (genvar n = 0; n < NUM_ALIAS; n++) begin : g_sel
    assign alias_sel_o[n] = (page == PAGE_W'(n + 1));
  end

  always_comb begin
    assert (!(is_primary_o && (alias_sel_o != '0)));
    assert ($onehot0(alias_sel_o));
  end
endmodule

// File: rtl/mrw_gate.sv
module mrw_gate #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned NUM_ALIAS = 4,
  parameter int unsigned IDX_W     = 10,
  parameter logic [NUM_REGS-1:0] PRIV_MASK = '0
) (
  input  logic                 wr_i,
  input  logic                 is_primary_i,
  input  logic [NUM_ALIAS-1:0] alias_sel_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_REGS-1:0]  acl_i [NUM_ALIAS],
  output logic [NUM_REGS-1:0]  reg_we_o,
  output logic [NUM_ALIAS-1:0] acl_we_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [NUM_ALIAS-1:0] col;
    logic                 alias_ok;
    for (genvar n = 0; n < NUM_ALIAS; n++) begin : g_col
      assign col[n] = acl_i[n][i];
    end
    if (PRIV_MASK[i]) begin : g_priv
      assign alias_ok = 1'b0;
    end else begin : g_open
      assign alias_ok = |(col & alias_sel_i);
    end
    assign reg_we_o[i] = wr_i && (idx_i == IDX_W'(i)) && (is_primary_i || alias_ok);
  end

  // masks: primary page only
  for (genvar n = 0; n < NUM_ALIAS; n++) begin : g_acl
    assign acl_we_o[n] = wr_i && is_primary_i && (idx_i == IDX_W'(NUM_REGS + n));
  end

  always_comb begin
    assert ($onehot0({reg_we_o, acl_we_o}));
  end
endmodule

// File: rtl/mrw_store.sv
module mrw_store #(
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned NUM_ALIAS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_REGS-1:0]  reg_we_i,
  input  logic [NUM_ALIAS-1:0] acl_we_i,
  output logic [DATA_W-1:0]    reg_q_o [NUM_REGS],
  output logic [NUM_REGS-1:0]  acl_q_o [NUM_ALIAS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          reg_q_o[i] <= '0;
      else if (reg_we_i[i]) reg_q_o[i] <= wdata_i;
    end
  end

  for (genvar n = 0; n < NUM_ALIAS; n++) begin : g_acl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          acl_q_o[n] <= '0;
      else if (acl_we_i[n]) acl_q_o[n] <= wdata_i[NUM_REGS-1:0];
    end
  end
endmodule

// File: rtl/mrw_window.sv
module mrw_window
  import mrw_pkg::*;
#(
  parameter int unsigned NUM_REGS  = MRW_NUM_REGS,
  parameter int unsigned NUM_ALIAS = MRW_NUM_ALIAS,
  parameter int unsigned DATA_W    = MRW_DATA_W,
  parameter logic [NUM_REGS-1:0] PRIV_MASK = MRW_PRIV_MASK,
  localparam int unsigned PAGE_W   = $clog2(NUM_ALIAS + 1),
  localparam int unsigned IDX_W    = MRW_IDX_W,
  localparam int unsigned ADDR_W   = MRW_PAGE_OFS + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic                 in_window, is_primary, wr, rd;
  logic [NUM_ALIAS-1:0] alias_sel;
  logic [IDX_W-1:0]     idx;
  logic [NUM_REGS-1:0]  reg_we;
  logic [NUM_ALIAS-1:0] acl_we;
  logic [DATA_W-1:0]    reg_q [NUM_REGS];
  logic [NUM_REGS-1:0]  acl_q [NUM_ALIAS];
  logic [DATA_W-1:0]    rd_d;

  mrw_decode #(.NUM_ALIAS(NUM_ALIAS), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_dec (
    .addr_i      (addr_i),
    .in_window_o (in_window),
    .is_primary_o(is_primary),
    .alias_sel_o (alias_sel),
    .idx_o       (idx)
  );

  assign wr = req_i && we_i && in_window;
  assign rd = req_i && !we_i;

  mrw_gate #(
    .NUM_REGS(NUM_REGS), .NUM_ALIAS(NUM_ALIAS), .IDX_W(IDX_W), .PRIV_MASK(PRIV_MASK)
  ) u_gate (
    .wr_i        (wr),
    .is_primary_i(is_primary),
    .alias_sel_i (alias_sel),
    .idx_i       (idx),
    .acl_i       (acl_q),
    .reg_we_o    (reg_we),
    .acl_we_o    (acl_we)
  );

  mrw_store #(.NUM_REGS(NUM_REGS), .NUM_ALIAS(NUM_ALIAS), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wdata_i (wdata_i),
    .reg_we_i(reg_we),
    .acl_we_i(acl_we),
    .reg_q_o (reg_q),
    .acl_q_o (acl_q)
  );

  // read path ignores the page once inside the window
  always_comb begin
    rd_d = '0;
    if (in_window) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) rd_d = reg_q[i];
      for (int n = 0; n < NUM_ALIAS; n++)
        if (idx == IDX_W'(NUM_REGS + n)) rd_d = DATA_W'(acl_q[n]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end

  AST_OUT_WINDOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !in_window) |=> (rdata_o == '0)); // R7

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ast
    if (PRIV_MASK[i]) begin : g_priv
      AST_PRIV_ALIAS_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && we_i && addr_i[ADDR_W-1:12] == '0 && addr_i[11:2] == IDX_W'(i))
        |=> $stable(reg_q[i])); // R5
    end else begin : g_open
      AST_ACL_CLOSED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i[ADDR_W-1:12] != '0 && addr_i[11:2] == IDX_W'(i)
         && ((alias_sel & {acl_q[3][i], acl_q[2][i], acl_q[1][i], acl_q[0][i]}) == '0))
        |=> $stable(reg_q[i])); // R4
    end
  end

  for (genvar n = 0; n < NUM_ALIAS; n++) begin : g_ast_acl
    AST_ACL_PRIMARY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && we_i && addr_i[ADDR_W-1:12] == '0 && addr_i[11:2] == IDX_W'(NUM_REGS + n))
      |=> $stable(acl_q[n])); // R6
  end
endmodule

// File: tb/tb_mrw_window.sv
module tb_mrw_window;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  mrw_window dut (.*);

  typedef struct packed {
    logic [7:0]  rq;
    logic        we;
    logic [14:0] addr;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, 15'h0004, 32'h1111_1111, 32'h0},           // R2 primary write reg1
    '{8'd2,  1'b0, 15'h0004, 32'h0,         32'h1111_1111},   // R2
    '{8'd3,  1'b0, 15'h3004, 32'h0,         32'h1111_1111},   // R3 alias read
    '{8'd4,  1'b1, 15'h1010, 32'hAAAA_0004, 32'h0},           // R4 mask closed
    '{8'd4,  1'b0, 15'h0010, 32'h0,         32'h0},           // R4
    '{8'd10, 1'b1, 15'h0020, 32'hFFFF_FF10, 32'h0},           // open reg4 for page 1
    '{8'd10, 1'b0, 15'h0020, 32'h0,         32'h0000_0010},   // R10
    '{8'd4,  1'b1, 15'h1010, 32'hAAAA_0004, 32'h0},           // R4 mask open
    '{8'd3,  1'b0, 15'h4010, 32'h0,         32'hAAAA_0004},   // R3
    '{8'd9,  1'b1, 15'h2010, 32'hBBBB_0000, 32'h0},           // R9 page 2 closed
    '{8'd9,  1'b0, 15'h0010, 32'h0,         32'hAAAA_0004},   // R9
    '{8'd5,  1'b1, 15'h0024, 32'h0000_00FF, 32'h0},           // open all for page 2
    '{8'd5,  1'b1, 15'h2000, 32'hDEAD_0000, 32'h0},           // R5 priv reg0
    '{8'd5,  1'b0, 15'h0000, 32'h0,         32'h0},           // R5
    '{8'd6,  1'b1, 15'h2020, 32'h0,         32'h0},           // R6 alias writes mask
    '{8'd6,  1'b0, 15'h0020, 32'h0,         32'h0000_0010},   // R6
    '{8'd4,  1'b1, 15'h2014, 32'h0000_0005, 32'h0},           // R4 page 2 reg5
    '{8'd4,  1'b0, 15'h1014, 32'h0,         32'h0000_0005},   // R4
    '{8'd7,  1'b1, 15'h5004, 32'h0000_0009, 32'h0},           // R7 write page 5
    '{8'd7,  1'b0, 15'h5004, 32'h0,         32'h0},           // R7
    '{8'd7,  1'b0, 15'h0004, 32'h0,         32'h1111_1111},   // R7 reg1 intact
    '{8'd8,  1'b1, 15'h0030, 32'h0000_0007, 32'h0},           // R8 index 12
    '{8'd8,  1'b0, 15'h0030, 32'h0,         32'h0},           // R8
    '{8'd7,  1'b0, 15'h7FFC, 32'h0,         32'h0}            // R7 top of space
  };

  task automatic access(input logic w, input logic [14:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic read_chk(input int rq, input logic [14:0] a, input logic [31:0] exp);
    access(1'b0, a, 32'h0);
    check(rq, rdata_o, exp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, rdata_o, 32'h0);                 // R1 rdata after reset
    rst_ni = 1'b1;
    read_chk(1, 15'h001C, 32'h0);             // R1 reg7
    read_chk(1, 15'h002C, 32'h0);             // R1 mask page 4
    access(1'b1, 15'h401C, 32'h1234_5678);    // R1 page 4 protected at reset
    read_chk(1, 15'h001C, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].we) access(1'b1, VEC[k].addr, VEC[k].d);
      else           read_chk(int'(VEC[k].rq), VEC[k].addr, VEC[k].exp);
    end

    // R3 rdata holds across a write
    access(1'b1, 15'h0018, 32'hCAFE_0006);
    check(3, rdata_o, 32'h0);
    read_chk(2, 15'h0018, 32'hCAFE_0006);     // R2 reg6 written through primary
    // R9 page 3 still closed while pages 1 and 2 have masks set
    access(1'b1, 15'h3018, 32'h0000_0BAD);
    read_chk(9, 15'h0018, 32'hCAFE_0006);
    // R5 priv reg2 through page 2 with all mask bits open
    access(1'b1, 15'h2008, 32'h0000_0002);
    read_chk(5, 15'h0008, 32'h0);

    // R1 reset mid-run clears storage and masks
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); check(1, rdata_o, 32'h0);
    rst_ni = 1'b1;
    read_chk(1, 15'h0004, 32'h0);
    read_chk(1, 15'h0024, 32'h0);
    access(1'b1, 15'h2014, 32'h0000_0077);    // R1 page 2 closed again
    read_chk(1, 15'h0014, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule